// File: doc/BRIEF.md
# Asynchronous-Load Up/Down Binary Counter

This block is a binary counter that steps once per rising clock edge, up or down as a direction input selects. Stepping happens only while an active-low count enable is asserted. A level-sensitive load input forces the count to the value on a data bus at once, with no clock edge needed. A master clear input drives the count to zero at once and wins over every other input. The counter wraps at both ends of its range.

An active-low terminal-count output is built from the visible count, the direction and the enable with no register in the path. It goes low only when the enabled counter is about to wrap. A following stage can take it directly as its own active-low enable in the same cycle, so stages chain for counting in either direction. The width is a parameter.

Top module: `updown_counter`

## Requirements
- R1: While `clr_i` is 1, `q_o` is all zeros at once, whatever the clock, load, enable, direction and data inputs are doing, and this holds during a load as well.
- R2: While `ld_i` is 1 and `clr_i` is 0, `q_o` equals `d_i` at once and follows every change of `d_i` with no clock edge.
- R3: When `ld_i` and `clr_i` are both 0, the count changes only on a rising `clk` edge and only if `cen_n_i` is 0. With `cen_n_i` at 1 the count holds across edges.
- R4: On an enabled edge, `up_i`=1 adds one to the count and `up_i`=0 subtracts one.
- R5: Counting up from all ones gives zero, and counting down from zero gives all ones.
- R6: With `cen_n_i`=0 and `up_i`=1, `tc_n_o` is 0 exactly when `q_o` is all ones.
- R7: With `cen_n_i`=0 and `up_i`=0, `tc_n_o` is 0 exactly when `q_o` is zero. With `cen_n_i`=1, `tc_n_o` is 1 for any count.
- R8: The all-ones and all-zeros detection, and the wrap, cover the full width `W` for any value of that parameter.
- R9: After `ld_i` falls, counting resumes from the loaded value. This requires that `d_i` was held through at least one rising edge while `ld_i` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| clr_i | input | 1 | Asynchronous master clear, active high |
| ld_i | input | 1 | Asynchronous level-sensitive load, active high |
| d_i | input | W | Load data |
| cen_n_i | input | 1 | Count enable, active low |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| q_o | output | W | Current count |
| tc_n_o | output | 1 | Terminal count, active low, combinational |

## Verification
The bench builds two copies of the counter. One uses the default `W`=4. At that width the whole range from 0 to 15, both wrap points and every load value the vectors use can be reached in a few dozen cycles. The other uses `W`=6, which shows that the terminal-count detection and the wrap follow the width parameter rather than a fixed four-bit pattern. In that copy the down-wrap lands on 63 and the terminal count goes low both at 0 counting down and at 63 counting up.

// File: rtl/updown_counter.sv
module updown_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  input  logic         cen_n_i,
  input  logic         up_i,
  output logic [W-1:0] q_o,
  output logic         tc_n_o
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] st;
  logic [W-1:0] stepped;
  logic         at_end;

  assign stepped = up_i ? st + ONE : st - ONE;

  always_ff @(posedge clk or posedge clr_i or posedge ld_i) begin
    if (clr_i)         st <= ZERO;
    else if (ld_i)     st <= d_i;
    else if (!cen_n_i) st <= stepped;
  end

  assign q_o    = clr_i ? ZERO : (ld_i ? d_i : st);
  assign at_end = up_i ? (q_o == ONES) : (q_o == ZERO);
  assign tc_n_o = ~(~cen_n_i & at_end);

endmodule

// File: rtl/updown_counter_chk.sv
module updown_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr_i,
  input logic         ld_i,
  input logic [W-1:0] d_i,
  input logic         cen_n_i,
  input logic         up_i,
  input logic [W-1:0] q_o,
  input logic         tc_n_o
);

  localparam logic [W-1:0] ONE = W'(1);

  // R1
  reset_zero_chk: assert property (@(posedge clk) clr_i |-> q_o == '0);

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (clr_i)
    ld_i |-> q_o == d_i);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (clr_i)
    (!ld_i && $past(!ld_i && !clr_i && cen_n_i)) |-> q_o == $past(q_o));

  // R4 R5
  count_up_chk: assert property (@(posedge clk) disable iff (clr_i)
    (!ld_i && $past(!ld_i && !clr_i && !cen_n_i && up_i)) |-> q_o == $past(q_o) + ONE);

  // R4 R5
  count_down_chk: assert property (@(posedge clk) disable iff (clr_i)
    (!ld_i && $past(!ld_i && !clr_i && !cen_n_i && !up_i)) |-> q_o == $past(q_o) - ONE);

  // R6
  tc_up_chk: assert property (@(posedge clk) disable iff (clr_i)
    (!cen_n_i && up_i) |-> (tc_n_o == !(&q_o)));

  // R7
  tc_down_chk: assert property (@(posedge clk) disable iff (clr_i)
    (!cen_n_i && !up_i) |-> (tc_n_o == (|q_o)));

  // R7
  tc_gate_chk: assert property (@(posedge clk) disable iff (clr_i)
    cen_n_i |-> tc_n_o);

endmodule

bind updown_counter updown_counter_chk #(.W(W)) u_chk (.*);

// File: tb/updown_counter_bench.sv
module updown_counter_bench;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       ld = 1'b0;
  logic [3:0] d = '0;
  logic       cen_n = 1'b1;
  logic       up = 1'b1;
  logic [3:0] q;
  logic       tc_n;

  logic       b_ld = 1'b0;
  logic [5:0] b_d = '0;
  logic       b_cen_n = 1'b1;
  logic       b_up = 1'b1;
  logic [5:0] b_q;
  logic       b_tc_n;

  int runs = 0;
  int fails = 0;

  always #5 clk = ~clk;

  updown_counter #(.W(4)) u_updown_counter (
    .clk(clk), .clr_i(clr), .ld_i(ld), .d_i(d), .cen_n_i(cen_n), .up_i(up),
    .q_o(q), .tc_n_o(tc_n));

  updown_counter #(.W(6)) u_updown_counter_w6 (
    .clk(clk), .clr_i(clr), .ld_i(b_ld), .d_i(b_d), .cen_n_i(b_cen_n), .up_i(b_up),
    .q_o(b_q), .tc_n_o(b_tc_n));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // {ld, d[3:0], cen_n, up, q_exp[3:0], tc_n_exp}
  localparam int NV = 16;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 4'h0, 1'b1, 1'b1, 4'h0, 1'b1},  // R3 hold
    {1'b0, 4'h0, 1'b0, 1'b1, 4'h1, 1'b1},  // R4 up
    {1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0},  // R4 down, R7 tc at zero
    {1'b0, 4'h0, 1'b0, 1'b0, 4'hF, 1'b1},  // R5 down wrap
    {1'b0, 4'h0, 1'b0, 1'b1, 4'h0, 1'b1},  // R5 up wrap
    {1'b1, 4'hE, 1'b0, 1'b1, 4'hE, 1'b1},  // R2 load
    {1'b0, 4'h0, 1'b0, 1'b1, 4'hF, 1'b0},  // R9 resume, R6
    {1'b0, 4'h0, 1'b1, 1'b1, 4'hF, 1'b1},  // R3 hold, R7 gate
    {1'b0, 4'h0, 1'b0, 1'b1, 4'h0, 1'b1},  // R5
    {1'b1, 4'h5, 1'b0, 1'b0, 4'h5, 1'b1},  // R2
    {1'b0, 4'h0, 1'b0, 1'b0, 4'h4, 1'b1},  // R9
    {1'b0, 4'h0, 1'b1, 1'b0, 4'h4, 1'b1},  // R3
    {1'b0, 4'h0, 1'b0, 1'b1, 4'h5, 1'b1},  // R4
    {1'b1, 4'h0, 1'b1, 1'b0, 4'h0, 1'b1},  // R2 R7
    {1'b0, 4'h0, 1'b0, 1'b0, 4'hF, 1'b1},  // R5
    {1'b0, 4'h0, 1'b0, 1'b1, 4'h0, 1'b1}   // R5
  };

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    runs++;
    fails++;
    $display("FAIL R3: watchdog expired, got 0 expected 1");
    finish_run();
  end

  initial begin
    #2;
    chk("R1 reset count", 8'(q), 8'h0);
    chk("R7 reset tc", 8'(tc_n), 8'h1);
    @(negedge clk);
    @(negedge clk);
    clr = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ld, d, cen_n, up} = VEC[i][11:5];
      @(posedge clk);
      #2;
      chk($sformatf("R3/R4/R5 vector %0d count", i), 8'(q), 8'(VEC[i][4:1]));
      chk($sformatf("R6/R7 vector %0d tc", i), 8'(tc_n), 8'(VEC[i][0]));
    end

    // load follows data, then released mid-cycle
    @(negedge clk);
    ld = 1'b1; d = 4'hA; cen_n = 1'b0; up = 1'b1;
    #1 chk("R2 async load", 8'(q), 8'hA);
    d = 4'h3;
    #1 chk("R2 follow data", 8'(q), 8'h3);
    d = 4'hA;
    @(posedge clk);
    #3 ld = 1'b0;
    #1 chk("R9 value after mid-cycle release", 8'(q), 8'hA);
    @(posedge clk);
    #2 chk("R9 count resumes", 8'(q), 8'hB);

    // reset during load
    @(negedge clk);
    ld = 1'b1; d = 4'h7;
    #1 clr = 1'b1;
    #1 chk("R1 clear overrides load", 8'(q), 8'h0);
    clr = 1'b0;
    #1 chk("R2 load after clear", 8'(q), 8'h7);
    @(posedge clk);
    #2 chk("R2 load across edge", 8'(q), 8'h7);
    @(negedge clk);
    ld = 1'b0; cen_n = 1'b1;
    @(posedge clk);
    #2 chk("R3 hold after load", 8'(q), 8'h7);

    // terminal count, combinational
    @(negedge clk);
    ld = 1'b1; d = 4'hF; up = 1'b1; cen_n = 1'b0;
    #1 chk("R6 tc at all ones", 8'(tc_n), 8'h0);
    cen_n = 1'b1;
    #1 chk("R7 tc gated by enable", 8'(tc_n), 8'h1);
    up = 1'b0; d = 4'h0; cen_n = 1'b0;
    #1 chk("R7 tc at zero down", 8'(tc_n), 8'h0);
    up = 1'b1;
    #1 chk("R6 tc zero counting up", 8'(tc_n), 8'h1);
    @(posedge clk);
    @(negedge clk);
    ld = 1'b0; cen_n = 1'b1;

    // wider instance
    b_cen_n = 1'b0; b_up = 1'b0;
    #1 chk("R8 wide tc at zero", 8'(b_tc_n), 8'h0);
    @(posedge clk);
    #2 chk("R8 wide down wrap", 8'(b_q), 8'h3F);
    chk("R8 wide tc not at top down", 8'(b_tc_n), 8'h1);
    @(negedge clk);
    b_up = 1'b1;
    #1 chk("R8 wide tc at top", 8'(b_tc_n), 8'h0);
    @(posedge clk);
    #2 chk("R8 wide up wrap", 8'(b_q), 8'h00);
    @(negedge clk);
    b_cen_n = 1'b1;

    // final clear
    clr = 1'b1;
    #1 chk("R1 final clear", 8'(q), 8'h0);
    @(negedge clk);
    finish_run();
  end

endmodule